// File: doc/BRIEF.md
# Multi-Channel Periodic Interrupt Timer

This block is a register-mapped bank of identical down-counting timers. Each channel counts from a programmed reload value down to zero. When it leaves zero it latches a timeout flag and reloads, so it keeps firing at a fixed period. A channel drives its own interrupt line when its flag and its interrupt enable are both set, and an OR of all lines is also provided. Software sets up and services the channels through a plain 32-bit word-addressed read/write port. Reads are combinational, and a write takes effect at the clock edge on which `bus_sel` and `bus_wr` are high.

A bank-wide control word can stop every counter, either always (disable) or only while an external debug-halt input is high (freeze). Channel 1 can be linked to channel 0 so that it steps once per channel-0 timeout, which makes the pair work as one wide timer. Changing a reload value never disturbs a count in progress. The only ways to start over from a new value are to let the count wrap, or to clear and then set the enable bit.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the bank-control word reads 0x2 (disable bit 1 set, freeze bit 0 clear). Every channel's enable, interrupt-enable, link bit and flag are 0, and all interrupt outputs are low.
- R2: Address map (byte offsets, word aligned). Bank control is at 0x000. Channel n occupies 0x100+0x10*n, with reload at +0x0, live count at +0x4, control at +0x8 and flag at +0xC. Control bit 0 is enable, bit 1 is interrupt enable and bit 2 is the link bit, which exists only on channel 1 and reads 0 elsewhere. Any other offset, including channels at or above NUM_CH, reads 0.
- R3: A write that sets the enable bit while it was 0 loads the live count from the reload register at that edge.
- R4: A running channel decrements once per clock. On the step taken at zero it sets its flag and reloads, so a reload value of N gives a timeout every N+1 cycles.
- R5: Writing the reload register of a running channel leaves the count in progress untouched, and the new value is first used at the next wrap. Clearing and then setting enable restarts the count from the new value.
- R6: Writing 1 to flag bit 0 clears the flag and writing 0 has no effect. A timeout on the same edge as a clear wins, and the flag stays 1.
- R7: Interrupt line n is high exactly when flag n and interrupt-enable n are both 1. `irq_any` is the OR of all lines.
- R8: While the bank disable bit is 1, no counter moves and no flag is set.
- R9: While the freeze bit is 1 and `dbg_halt` is high, no counter moves. `dbg_halt` has no effect when freeze is 0.
- R10: With its link bit set, channel 1 steps once per channel-0 timeout instead of once per clock.
- R11: A channel with enable 0 holds its count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dbg_halt | input | 1 | Debug halt request, honoured when freeze is set |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | NUM_CH | Per-channel interrupt lines |
| irq_any | output | 1 | OR of all interrupt lines |

## Verification
A write lands on the edge that ends its bus cycle. A read returns the state left by the latest edge in the same cycle, with no added latency. An enabled channel shows its reload value right after the enabling edge. After k more edges it shows N-(k mod (N+1)), and its flag and interrupt line rise on edge N+1. The bench drives on the falling edge, reads just after a rising edge without consuming one, and counts each rising edge it lets pass. It compares every read with these formulas, including the edge consumed by each control write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;
  localparam logic [3:0] CH_PAGE = 4'h1;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_LIVE   = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_sel_e;

  localparam int BIT_FRZ   = 0;
  localparam int BIT_DIS   = 1;
  localparam int BIT_EN    = 0;
  localparam int BIT_IE    = 1;
  localparam int BIT_LINK  = 2;
  localparam int BIT_FLAG  = 0;
endpackage

// File: rtl/tmr_regdec.sv
module tmr_regdec
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  output logic              bank_hit,
  output logic [NUM_CH-1:0] ch_hit,
  output reg_sel_e          reg_sel,
  output logic              bank_we,
  output logic [NUM_CH-1:0] reload_we,
  output logic [NUM_CH-1:0] ctrl_we,
  output logic [NUM_CH-1:0] flag_we
);
  logic unused_addr_lsb;
  assign unused_addr_lsb = ^addr[1:0];

  assign bank_hit = sel && (addr[ADDR_W-1:2] == '0);
  assign bank_we  = bank_hit && wr;
  assign reg_sel  = reg_sel_e'(addr[3:2]);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign ch_hit[i]    = sel && (addr[11:8] == CH_PAGE) && (addr[7:4] == 4'(i));
    assign reload_we[i] = ch_hit[i] && wr && (reg_sel == REG_RELOAD);
    assign ctrl_we[i]   = ch_hit[i] && wr && (reg_sel == REG_CTRL);
    assign flag_we[i]   = ch_hit[i] && wr && (reg_sel == REG_FLAG);
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int CNT_W   = 32,
  parameter bit LINK_OK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_we,
  input  logic              ctrl_we,
  input  logic              flag_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              step_ok,
  input  logic              link_pulse,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              en_o,
  output logic              ie_o,
  output logic              link_o,
  output logic              flag_o,
  output logic              expire_o
);
  logic [CNT_W-1:0] cnt_q, reload_q;
  logic en_q, ie_q, flag_q, link_q;
  logic tick, start;

  if (LINK_OK) begin : g_link
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       link_q <= 1'b0;
      else if (ctrl_we) link_q <= wdata[BIT_LINK];
    end
  end else begin : g_nolink
    logic unused_link;
    assign unused_link = link_pulse;
    assign link_q = 1'b0;
  end

  assign tick     = en_q && step_ok && (link_q ? link_pulse : 1'b1);
  assign start    = ctrl_we && wdata[BIT_EN] && !en_q;
  assign expire_o = tick && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
    end else if (ctrl_we) begin
      en_q <= wdata[BIT_EN];
      ie_q <= wdata[BIT_IE];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         reload_q <= '0;
    else if (reload_we) reload_q <= wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (start)    cnt_q <= reload_q;
    else if (tick)     cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          flag_q <= 1'b0;
    else if (expire_o)                   flag_q <= 1'b1;
    else if (flag_we && wdata[BIT_FLAG]) flag_q <= 1'b0;
  end

  assign cnt_o    = cnt_q;
  assign reload_o = reload_q;
  assign en_o     = en_q;
  assign ie_o     = ie_q;
  assign link_o   = link_q;
  assign flag_o   = flag_q;

  a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
  a_r4_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !start && cnt_q == '0) |=> cnt_q == $past(reload_q));
  a_r4_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick && cnt_q == '0));
  a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !start) |=> $stable(cnt_q));
  a_r3_start_load: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (cnt_q == $past(reload_q)) && en_q);
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tmr_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_halt,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [11:0]       bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq,
  output logic              irq_any
);
  logic frz_q, dis_q, step_ok;
  logic bank_hit, bank_we;
  logic [NUM_CH-1:0] ch_hit, reload_we, ctrl_we, flag_we;
  reg_sel_e reg_sel;

  logic [CNT_W-1:0] cnt_a    [NUM_CH];
  logic [CNT_W-1:0] reload_a [NUM_CH];
  logic [NUM_CH-1:0] en_v, ie_v, link_v, flag_v, exp_v;

  tmr_regdec #(.NUM_CH(NUM_CH)) u_dec (
    .sel(bus_sel), .wr(bus_wr), .addr(bus_addr),
    .bank_hit(bank_hit), .ch_hit(ch_hit), .reg_sel(reg_sel),
    .bank_we(bank_we), .reload_we(reload_we), .ctrl_we(ctrl_we), .flag_we(flag_we)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_q <= 1'b0;
      dis_q <= 1'b1;
    end else if (bank_we) begin
      frz_q <= bus_wdata[BIT_FRZ];
      dis_q <= bus_wdata[BIT_DIS];
    end
  end

  assign step_ok = !dis_q && !(frz_q && dbg_halt);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic link_in;
    if (i == 1) begin : g_l
      assign link_in = exp_v[0];
    end else begin : g_n
      assign link_in = 1'b0;
    end
    tmr_channel #(.CNT_W(CNT_W), .LINK_OK(i == 1)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .reload_we(reload_we[i]), .ctrl_we(ctrl_we[i]), .flag_we(flag_we[i]),
      .wdata(bus_wdata), .step_ok(step_ok), .link_pulse(link_in),
      .cnt_o(cnt_a[i]), .reload_o(reload_a[i]),
      .en_o(en_v[i]), .ie_o(ie_v[i]), .link_o(link_v[i]),
      .flag_o(flag_v[i]), .expire_o(exp_v[i])
    );
  end

  assign irq     = flag_v & ie_v;
  assign irq_any = |irq;

  always_comb begin
    bus_rdata = '0;
    if (bank_hit) begin
      bus_rdata[BIT_FRZ] = frz_q;
      bus_rdata[BIT_DIS] = dis_q;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_hit[i]) begin
        unique case (reg_sel)
          REG_RELOAD: bus_rdata = DATA_W'(reload_a[i]);
          REG_LIVE:   bus_rdata = DATA_W'(cnt_a[i]);
          REG_CTRL:   bus_rdata = {29'b0, link_v[i], ie_v[i], en_v[i]};
          REG_FLAG:   bus_rdata = {31'b0, flag_v[i]};
        endcase
      end
    end
  end

  a_r8_no_flag_while_off: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |=> ((flag_v & ~$past(flag_v)) == '0));
  a_r9_frozen_no_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_q && dbg_halt) |-> exp_v == '0);
  a_r7_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
    irq_any |-> ((flag_v & ie_v) != '0));
endmodule

// File: tb/sim_tick_timer_bank.sv
module sim_tick_timer_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0, rst_n = 1'b0, dbg_halt = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;
  logic irq_any;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_timer_bank #(.NUM_CH(NCH), .CNT_W(32)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_halt(dbg_halt),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .irq_any(irq_any)
  );

  function automatic logic [11:0] ch_addr(int ch, int off);
    return 12'(32'h100 + 32'h10 * ch + off);
  endfunction

  function automatic logic [31:0] exp_cnt(int n, int k);
    return 32'(n - (k % (n + 1)));
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic step(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [31:0] v, snap;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1 reset state
    rd(12'h000, v); check("R1 bank ctrl", v, 32'h2);
    rd(ch_addr(0, 8), v); check("R1 ctrl0", v, 0);
    rd(ch_addr(3, 12), v); check("R1 flag3", v, 0);
    check("R1 irq", {27'b0, irq_any, irq}, 0);

    // R2 unused offsets
    rd(12'h004, v); check("R2 unused bank offset", v, 0);
    rd(ch_addr(NCH, 4), v); check("R2 missing channel", v, 0);

    // R8 disabled bank: enable ch0 while bank off
    wr(ch_addr(0, 0), 5);
    wr(ch_addr(0, 8), 1);
    rd(ch_addr(0, 4), v); check("R3 load on enable", v, 5);
    step(12);
    rd(ch_addr(0, 4), v); check("R8 count held", v, 5);
    rd(ch_addr(0, 12), v); check("R8 no flag", v, 0);

    // bank on; restart ch0 with N=20
    wr(12'h000, 0);
    wr(ch_addr(0, 8), 0);
    wr(ch_addr(0, 0), 20);
    wr(ch_addr(0, 8), 1);
    step(5);
    rd(ch_addr(0, 4), v); check("R4 count 15", v, 15);
    wr(ch_addr(0, 0), 7);
    rd(ch_addr(0, 4), v); check("R5 no restart on reload write", v, 14);
    step(14);
    rd(ch_addr(0, 4), v); check("R4 reached zero", v, 0);
    rd(ch_addr(0, 12), v); check("R4 no flag before wrap", v, 0);
    step(1);
    rd(ch_addr(0, 4), v); check("R5 new reload at wrap", v, 7);
    rd(ch_addr(0, 12), v); check("R4 flag at wrap", v, 1);
    check("R7 no irq with ie=0", {31'b0, irq[0]}, 0);

    // R6 flag write rules
    wr(ch_addr(0, 12), 0);
    rd(ch_addr(0, 12), v); check("R6 write 0 ignored", v, 1);
    wr(ch_addr(0, 12), 1);
    rd(ch_addr(0, 12), v); check("R6 write 1 clears", v, 0);

    // R11 disable holds, R5 restart
    wr(ch_addr(0, 8), 0);
    rd(ch_addr(0, 4), snap);
    step(6);
    rd(ch_addr(0, 4), v); check("R11 idle holds", v, snap);
    wr(ch_addr(0, 0), 9);
    wr(ch_addr(0, 8), 1);
    rd(ch_addr(0, 4), v); check("R5 restart from new value", v, 9);

    // R7 interrupt
    wr(ch_addr(0, 8), 32'h7);
    rd(ch_addr(0, 8), v); check("R2 link bit absent on ch0", v, 3);
    rd(ch_addr(0, 4), v); check("R3 no reload when already on", v, 8);
    step(8);
    check("R7 irq low before wrap", {31'b0, irq_any}, 0);
    step(1);
    check("R7 irq line", {28'b0, irq}, 4'b0001);
    check("R7 irq_any", {31'b0, irq_any}, 1);
    wr(ch_addr(0, 8), 1);
    check("R7 ie off drops irq", {31'b0, irq_any}, 0);
    wr(ch_addr(0, 12), 1);

    // R6 set wins over clear (ch2, N=3)
    wr(ch_addr(2, 0), 3);
    wr(ch_addr(2, 8), 1);
    step(3);
    wr(ch_addr(2, 12), 1);
    rd(ch_addr(2, 12), v); check("R6 set wins", v, 1);
    wr(ch_addr(2, 8), 0);

    // R4 random periods on ch3
    for (int it = 0; it < 8; it++) begin
      int n, k;
      n = 1 + int'($urandom % 20);
      k = int'($urandom % 70);
      wr(ch_addr(3, 8), 0);
      wr(ch_addr(3, 0), 32'(n));
      wr(ch_addr(3, 12), 1);
      wr(ch_addr(3, 8), 1);
      step(k);
      rd(ch_addr(3, 4), v); check("R4 random count", v, exp_cnt(n, k));
      rd(ch_addr(3, 12), v); check("R4 random flag", v, (k >= n + 1) ? 1 : 0);
    end
    wr(ch_addr(3, 8), 0);

    // R9 freeze
    wr(ch_addr(0, 8), 0);
    wr(ch_addr(0, 0), 1000);
    wr(ch_addr(0, 8), 1);
    dbg_halt = 1'b1;
    step(4);
    rd(ch_addr(0, 4), v); check("R9 halt ignored w/o freeze", v, 996);
    wr(12'h000, 1);
    rd(ch_addr(0, 4), snap);
    step(7);
    rd(ch_addr(0, 4), v); check("R9 frozen", v, snap);
    dbg_halt = 1'b0;
    step(2);
    rd(ch_addr(0, 4), v); check("R9 resumes", v, snap - 2);
    wr(12'h000, 0);

    // R10 link
    wr(ch_addr(0, 8), 0);
    wr(ch_addr(0, 0), 2);
    wr(ch_addr(1, 0), 4);
    wr(ch_addr(1, 8), 32'h5);
    rd(ch_addr(1, 8), v); check("R2 ch1 link readback", v, 5);
    step(5);
    rd(ch_addr(1, 4), v); check("R10 idle without ch0", v, 4);
    wr(ch_addr(0, 8), 1);
    step(9);
    rd(ch_addr(1, 4), v); check("R10 linked count", v, 1);
    rd(ch_addr(0, 4), v); check("R10 ch0 phase", v, 2);

    // R8 no flags with bank disabled while running
    wr(ch_addr(0, 12), 1);
    wr(12'h000, 2);
    rd(ch_addr(0, 4), snap);
    step(10);
    rd(ch_addr(0, 4), v); check("R8 frozen by disable", v, snap);
    rd(ch_addr(0, 12), v); check("R8 flag stays clear", v, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule